// File: doc/BRIEF.md
# Serial Register Access Port with Selectable Framing

This block is a serial slave that reads and writes a byte-wide register file reached through 13-bit addresses. It runs on a fast system clock and sees the serial clock, chip select and data pins as already-synchronised inputs. It finds the serial clock edges by comparing each sample with the one before. Every transfer starts with a 16-bit instruction word, followed by one or more data bytes. The address moves on by one after each byte.

A configuration byte at address 0x000 controls the framing:

- **Bit order:** most significant bit first or least significant bit first.
- **Address step:** one mode bit picks the bit order and the step direction together. MSB-first counts down and LSB-first counts up.
- **Read pin:** read data leaves on the shared data line, or on a separate output line.
- **Soft reset:** a self-clearing bit returns every register to its default.

The low nibble of the configuration byte mirrors the high nibble. A byte written this way arrives the same in either bit order.

A bank of general registers is kept twice. The buffer copy is written over the serial link. The active copy drives the parallel outputs, and an update command loads it from the buffer copy. A readback-select bit picks which copy a read returns.

Top module: `spi_ctrl_port`

## Requirements
- R1: The instruction word is 16 bits, shifted in the current bit order.
  - Bit 15 is read (1) or write (0).
  - Bits 14:13 give the byte count: 00, 01 and 10 mean 1, 2 and 3 bytes. 11 means stream until CS_N rises.
  - Bits 12:0 are the start address.
  - Bits clocked in after the byte count is used up have no effect.
- R2: Input bits are taken on rising SCLK edges. Read data changes only after a falling SCLK edge, and stays stable while SCLK is high.
- R3: With configuration bit 6 at 0 (the default), data is shifted MSB first and the address decrements after each byte.
- R4: With configuration bit 6 at 1, data is shifted LSB first and the address increments after each byte.
- R5: The read output pin follows configuration bit 7.
  - At 0 (the default), read data is driven on SDIO (sdio_oe high) and sdo_oe stays low.
  - At 1, read data is driven on SDO (sdo_oe high) and sdio_oe stays low.
  - Both enables are low while CS_N is high.
- R6: A write to address 0x000 keeps bits 7 and 6 and reads back as {b7,b6,0,0,0,0,b6,b7}. The new framing takes effect only after CS_N rises.
- R7: Writing a byte with bit 5 set to address 0x000 resets every register to its default:
  - the configuration byte, the readback select and both ID bytes go to 0x00;
  - buffer and active general register i both go to 0xA0 XOR i.
  The bit itself reads back as 0.
- R8: The general registers sit at 0x010 to 0x01F. A write changes only the buffer copy. Writing bit 0 = 1 to 0x232 copies every buffer register into the active copy. Address 0x232 reads 0. Active register i appears on active_regs[8i+7:8i].
- R9: Bit 0 of 0x004 selects the read source for general registers: 0 (the default) returns the buffer copy and 1 returns the active copy.
- R10: Addresses 0x005 (low byte) and 0x006 (high byte) form a 16-bit ID. It resets to zero, reads back what was written, and has no other effect.
- R11: Addresses that are not mapped read 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select that frames a transfer |
| sdio_in | input | 1 | Serial data into the block |
| sdio_out | output | 1 | Read data on the shared line |
| sdio_oe | output | 1 | Output enable for the shared line |
| sdo_out | output | 1 | Read data on the separate output line |
| sdo_oe | output | 1 | Output enable for the separate output line |
| active_regs | output | 128 | Active copies of the general registers |

## Verification
A read bit changes one system clock after the falling SCLK edge is detected. The bench therefore samples it three system clocks into the low phase, just before it raises SCLK. A written byte reaches its register two system clocks after the eighth rising edge, and a framing change waits for CS_N to rise. Register and mode checks therefore run only in a later transfer. The parallel active outputs are compared only once a transfer has closed, so an update command has had its cycle to land.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;

    localparam int ADR_CFG   = 'h000;
    localparam int ADR_RBSEL = 'h004;
    localparam int ADR_ID_LO = 'h005;
    localparam int ADR_ID_HI = 'h006;
    localparam int ADR_UPD   = 'h232;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_INSTR,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Reset value of general register idx.
    function automatic logic [7:0] gp_default(input int idx);
        return 8'hA0 ^ 8'(idx);
    endfunction

    // Keep the two mode bits and mirror them into the low nibble.
    function automatic logic [7:0] cfg_mirror(input logic [7:0] b);
        return {b[7], b[6], 4'b0000, b[6], b[7]};
    endfunction

endpackage

// File: rtl/spi_ctrl_frame.sv
module spi_ctrl_frame
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              lsb_first,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              dout,
    output logic              drive,
    output logic              cs_rise
);

    localparam int IW = ADDR_W + 3;
    localparam int CW = $clog2(IW + 1);

    typedef struct packed {
        logic              sclk;
        logic              cs_n;
        phase_e            ph;
        logic              rd;
        logic [CW-1:0]     bcnt;
        logic [1:0]        left;
        logic              strm;
        logic [ADDR_W-1:0] addr;
        logic [IW-1:0]     sh;
        logic              load;
        logic              dout;
        logic              drive;
        logic              wr_stb;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
    } frm_t;

    frm_t q, d;
    logic rise, fall;
    logic [IW-1:0] word;
    logic [7:0] byte_in;

    always_comb begin
        rise    = sclk & ~q.sclk;
        fall    = ~sclk & q.sclk;
        word    = lsb_first ? {sdi, q.sh[IW-1:1]} : {q.sh[IW-2:0], sdi};
        byte_in = lsb_first ? {sdi, q.sh[7:1]} : {q.sh[6:0], sdi};

        d        = q;
        d.sclk   = sclk;
        d.cs_n   = cs_n;
        d.wr_stb = 1'b0;
        d.load   = 1'b0;
        if (q.load) begin
            d.sh[7:0] = rdata;
        end

        if (cs_n) begin
            d.ph    = PH_IDLE;
            d.drive = 1'b0;
            d.bcnt  = '0;
        end else begin
            case (q.ph)
                PH_IDLE: begin
                    d.ph   = PH_INSTR;
                    d.bcnt = '0;
                end
                PH_INSTR: begin
                    if (rise) begin
                        d.sh   = word;
                        d.bcnt = q.bcnt + 1'b1;
                        if (q.bcnt == CW'(IW - 1)) begin
                            d.rd   = word[IW-1];
                            d.left = word[IW-2:IW-3];
                            d.strm = &word[IW-2:IW-3];
                            d.addr = word[ADDR_W-1:0];
                            d.bcnt = '0;
                            d.ph   = PH_DATA;
                            d.load = word[IW-1];
                        end
                    end
                end
                PH_DATA: begin
                    if (rise) begin
                        d.bcnt = q.bcnt + 1'b1;
                        if (!q.rd) begin
                            d.sh[7:0] = byte_in;
                        end
                        if (q.bcnt == CW'(7)) begin
                            d.bcnt    = '0;
                            d.wr_stb  = ~q.rd;
                            d.wr_addr = q.addr;
                            d.wr_data = byte_in;
                            d.addr    = lsb_first ? q.addr + 1'b1 : q.addr - 1'b1;
                            if (q.strm || (q.left != 2'd0)) begin
                                if (!q.strm) begin
                                    d.left = q.left - 1'b1;
                                end
                                d.load = q.rd;
                            end else begin
                                d.ph    = PH_DONE;
                                d.drive = 1'b0;
                            end
                        end
                    end else if (fall && q.rd) begin
                        d.dout    = lsb_first ? q.sh[0] : q.sh[7];
                        d.sh[7:0] = lsb_first ? {1'b0, q.sh[7:1]} : {q.sh[6:0], 1'b0};
                        d.drive   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign wr_stb  = q.wr_stb;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign dout    = q.dout;
    assign drive   = q.drive;
    assign cs_rise = cs_n & ~q.cs_n;

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int NUM_GP  = 16,
    parameter int GP_BASE = 'h010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                cs_rise,
    output logic [7:0]          rdata,
    output logic                frame_lsb,
    output logic                frame_sdo,
    output logic [NUM_GP*8-1:0] active_flat
);

    localparam int IDX_W = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

    typedef struct packed {
        logic [7:0]             cfg;
        logic                   rbsel;
        logic [7:0]             id_lo;
        logic [7:0]             id_hi;
        logic [NUM_GP-1:0][7:0] bank_b;
        logic [NUM_GP-1:0][7:0] bank_a;
        logic                   f_lsb;
        logic                   f_sdo;
    } reg_t;

    reg_t q, d;
    logic [ADDR_W-1:0] w_off, r_off;

    function automatic reg_t defaults();
        reg_t r;
        r = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            r.bank_b[i] = gp_default(i);
            r.bank_a[i] = gp_default(i);
        end
        return r;
    endfunction

    function automatic logic in_gp(input logic [ADDR_W-1:0] a);
        return (int'(a) >= GP_BASE) && (int'(a) < GP_BASE + NUM_GP);
    endfunction

    assign w_off = wr_addr - ADDR_W'(GP_BASE);
    assign r_off = rd_addr - ADDR_W'(GP_BASE);

    always_comb begin
        d = q;
        if (wr_stb) begin
            if (wr_addr == ADDR_W'(ADR_CFG)) begin
                if (wr_data[5]) begin
                    d       = defaults();
                    d.f_lsb = q.f_lsb;
                    d.f_sdo = q.f_sdo;
                end else begin
                    d.cfg = cfg_mirror(wr_data);
                end
            end else if (wr_addr == ADDR_W'(ADR_RBSEL)) begin
                d.rbsel = wr_data[0];
            end else if (wr_addr == ADDR_W'(ADR_ID_LO)) begin
                d.id_lo = wr_data;
            end else if (wr_addr == ADDR_W'(ADR_ID_HI)) begin
                d.id_hi = wr_data;
            end else if (wr_addr == ADDR_W'(ADR_UPD)) begin
                if (wr_data[0]) begin
                    d.bank_a = q.bank_b;
                end
            end else if (in_gp(wr_addr)) begin
                d.bank_b[w_off[IDX_W-1:0]] = wr_data;
            end
        end
        if (cs_rise) begin
            d.f_lsb = d.cfg[6];
            d.f_sdo = d.cfg[7];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (rd_addr == ADDR_W'(ADR_CFG)) begin
            rdata = q.cfg;
        end else if (rd_addr == ADDR_W'(ADR_RBSEL)) begin
            rdata = {7'b0, q.rbsel};
        end else if (rd_addr == ADDR_W'(ADR_ID_LO)) begin
            rdata = q.id_lo;
        end else if (rd_addr == ADDR_W'(ADR_ID_HI)) begin
            rdata = q.id_hi;
        end else if (in_gp(rd_addr)) begin
            rdata = q.rbsel ? q.bank_a[r_off[IDX_W-1:0]] : q.bank_b[r_off[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= defaults();
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NUM_GP; g++) begin : g_act
        assign active_flat[g*8 +: 8] = q.bank_a[g];
    end

    assign frame_lsb = q.f_lsb;
    assign frame_sdo = q.f_sdo;

endmodule

// File: rtl/spi_ctrl_port.sv
module spi_ctrl_port
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int NUM_GP  = 16,
    parameter int GP_BASE = 'h010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                sdio_in,
    output logic                sdio_out,
    output logic                sdio_oe,
    output logic                sdo_out,
    output logic                sdo_oe,
    output logic [NUM_GP*8-1:0] active_regs
);

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        rdata, wr_data;
    logic              wr_stb, dout, drive, cs_rise;
    logic              frame_lsb, frame_sdo;

    spi_ctrl_frame #(.ADDR_W(ADDR_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdio_in),
        .lsb_first (frame_lsb),
        .rdata     (rdata),
        .rd_addr   (rd_addr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dout      (dout),
        .drive     (drive),
        .cs_rise   (cs_rise)
    );

    spi_ctrl_regs #(.ADDR_W(ADDR_W), .NUM_GP(NUM_GP), .GP_BASE(GP_BASE)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .cs_rise     (cs_rise),
        .rdata       (rdata),
        .frame_lsb   (frame_lsb),
        .frame_sdo   (frame_sdo),
        .active_flat (active_regs)
    );

    assign sdio_out = dout;
    assign sdo_out  = dout;
    assign sdio_oe  = drive & ~frame_sdo;
    assign sdo_oe   = drive & frame_sdo;

endmodule

// File: rtl/spi_ctrl_port_chk.sv
module spi_ctrl_port_chk
    import spi_ctrl_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int NUM_GP = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sclk,
    input logic                cs_n,
    input logic                sdio_out,
    input logic                sdio_oe,
    input logic                sdo_oe,
    input logic [NUM_GP*8-1:0] active_regs,
    input logic                wr_stb,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                frame_lsb,
    input logic                frame_sdo
);

    p_oe_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> (!sdio_oe && !sdo_oe));

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdio_out));

    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && (wr_addr == ADDR_W'(ADR_UPD) || wr_addr == ADDR_W'(ADR_CFG)))
        |=> $stable(active_regs));

    p_frame_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(frame_lsb) && $stable(frame_sdo)));

endmodule

bind spi_ctrl_port spi_ctrl_port_chk #(.ADDR_W(ADDR_W), .NUM_GP(NUM_GP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .sdio_out    (sdio_out),
    .sdio_oe     (sdio_oe),
    .sdo_oe      (sdo_oe),
    .active_regs (active_regs),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .frame_lsb   (frame_lsb),
    .frame_sdo   (frame_sdo)
);

// File: tb/spi_ctrl_port_bench.sv
module spi_ctrl_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NUM_GP     = 16;
    localparam int GP_BASE    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [NUM_GP*8-1:0] active_regs;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ctrl_port u_spi_ctrl_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
        .active_regs(active_regs)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_cfg, m_id_lo, m_id_hi;
    logic       m_rb, m_lsb, m_four;
    logic [7:0] m_buf [NUM_GP];
    logic [7:0] m_act [NUM_GP];
    logic [7:0] tx_buf [32];
    logic [7:0] rx_buf [32];
    logic [7:0] ex_buf [32];
    bit         oe_bad;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg = 8'h00; m_rb = 1'b0; m_id_lo = 8'h00; m_id_hi = 8'h00;
        for (int i = 0; i < NUM_GP; i++) begin
            m_buf[i] = 8'hA0 ^ 8'(i);
            m_act[i] = 8'hA0 ^ 8'(i);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [12:0] a);
        if (a == 13'h000) return m_cfg;
        if (a == 13'h004) return {7'b0, m_rb};
        if (a == 13'h005) return m_id_lo;
        if (a == 13'h006) return m_id_hi;
        if (int'(a) >= GP_BASE && int'(a) < GP_BASE + NUM_GP)
            return m_rb ? m_act[int'(a) - GP_BASE] : m_buf[int'(a) - GP_BASE];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [12:0] a, input logic [7:0] v);
        if (a == 13'h000) begin
            if (v[5]) model_reset();
            else m_cfg = {v[7], v[6], 4'b0000, v[6], v[7]};
        end else if (a == 13'h004) m_rb = v[0];
        else if (a == 13'h005) m_id_lo = v;
        else if (a == 13'h006) m_id_hi = v;
        else if (a == 13'h232) begin
            if (v[0]) for (int i = 0; i < NUM_GP; i++) m_act[i] = m_buf[i];
        end else if (int'(a) >= GP_BASE && int'(a) < GP_BASE + NUM_GP)
            m_buf[int'(a) - GP_BASE] = v;
    endtask

    function automatic int eff_bytes(input int code, input int nb);
        if (code == 3) return nb;
        return (nb < code + 1) ? nb : code + 1;
    endfunction

    task automatic send_bit(input logic v, input bit rd, output logic r);
        @(negedge clk);
        sclk = 1'b0;
        sdio_in = v;
        repeat (HALF - 1) @(negedge clk);
        r = m_four ? sdo_out : sdio_out;
        if (rd && !(m_four ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe))) oe_bad = 1'b1;
        @(negedge clk);
        sclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic xfer(input bit rd, input int code, input int nb, input logic [12:0] a);
        logic [15:0] w;
        logic r;
        logic [7:0] rb;
        w = {rd, 2'(code), a};
        oe_bad = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) send_bit(m_lsb ? w[i] : w[15-i], 1'b0, r);
        for (int b = 0; b < nb; b++) begin
            rb = 8'h00;
            for (int i = 0; i < 8; i++) begin
                int k;
                k = m_lsb ? i : 7 - i;
                send_bit(tx_buf[b][k], rd, r);
                rb[k] = r;
            end
            rx_buf[b] = rb;
        end
        @(negedge clk);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic write_txn(input int code, input int nb, input logic [12:0] a);
        logic [12:0] p;
        xfer(1'b0, code, nb, a);
        p = a;
        for (int b = 0; b < eff_bytes(code, nb); b++) begin
            model_write(p, tx_buf[b]);
            p = m_lsb ? p + 13'd1 : p - 13'd1;
        end
        m_lsb = m_cfg[6];
        m_four = m_cfg[7];
    endtask

    task automatic read_check(input int code, input int nb, input logic [12:0] a, input string req);
        logic [12:0] p;
        p = a;
        for (int b = 0; b < nb; b++) begin
            ex_buf[b] = exp_read(p);
            p = m_lsb ? p + 13'd1 : p - 13'd1;
            tx_buf[b] = 8'(b * 37);
        end
        xfer(1'b1, code, nb, a);
        for (int b = 0; b < eff_bytes(code, nb); b++) chk(req, {24'b0, rx_buf[b]}, {24'b0, ex_buf[b]});
        chk("R5 read pin enable", {31'b0, oe_bad}, 32'd0);
    endtask

    task automatic chk_active(input string req);
        for (int i = 0; i < NUM_GP; i++) chk(req, {24'b0, active_regs[i*8 +: 8]}, {24'b0, m_act[i]});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        m_lsb = 1'b0;
        m_four = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state
        chk_active("R7 reset active");
        chk("R5 idle enables", {30'b0, sdio_oe, sdo_oe}, 32'd0);
        read_check(0, 1, 13'h000, "R6 cfg default");
        read_check(1, 2, 13'h006, "R10 id default");
        read_check(0, 1, 13'h013, "R2 first read");

        // R3: MSB first, decrementing stream of three bytes
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        write_txn(2, 3, 13'h012);
        read_check(0, 1, 13'h012, "R3");
        read_check(0, 1, 13'h010, "R3");
        read_check(3, 4, 13'h013, "R3 stream");

        // R8 and R9: buffer versus active before and after update
        chk_active("R8 active held");
        tx_buf[0] = 8'h01; write_txn(0, 1, 13'h004);
        read_check(0, 1, 13'h011, "R9 active readback");
        tx_buf[0] = 8'h01; write_txn(0, 1, 13'h232);
        chk_active("R8 after update");
        read_check(0, 1, 13'h232, "R8 update reads zero");
        tx_buf[0] = 8'h00; write_txn(0, 1, 13'h004);
        read_check(0, 1, 13'h004, "R9 select");

        // R1: bytes past the count are ignored
        tx_buf[0] = 8'h5A; tx_buf[1] = 8'hC3;
        write_txn(0, 2, 13'h015);
        read_check(1, 2, 13'h015, "R1");

        // R11: unmapped address
        tx_buf[0] = 8'hFF; write_txn(0, 1, 13'h100);
        read_check(0, 1, 13'h100, "R11");

        // R4 and R6: switch to LSB first
        tx_buf[0] = 8'h42; write_txn(0, 1, 13'h000);
        read_check(0, 1, 13'h000, "R6 mirror");
        tx_buf[0] = 8'h91; tx_buf[1] = 8'h92; tx_buf[2] = 8'h93; tx_buf[3] = 8'h94;
        write_txn(3, 4, 13'h018);
        read_check(3, 4, 13'h018, "R4");
        tx_buf[0] = 8'hBE; tx_buf[1] = 8'hEF;
        write_txn(1, 2, 13'h005);
        read_check(1, 2, 13'h005, "R10");

        // R5: four-wire read on the separate pin
        tx_buf[0] = 8'hC3; write_txn(0, 1, 13'h000);
        read_check(2, 3, 13'h01A, "R5 sdo read");

        // Random mix of modes, counts, addresses and updates
        for (int it = 0; it < 30; it++) begin
            logic [7:0] modes [4];
            int nb, code;
            logic [12:0] a;
            modes[0] = 8'h00; modes[1] = 8'h42; modes[2] = 8'h81; modes[3] = 8'hC3;
            tx_buf[0] = modes[$urandom % 4];
            write_txn(0, 1, 13'h000);
            nb = 1 + ($urandom % 5);
            code = (nb > 3) ? 3 : nb - 1;
            a = 13'(GP_BASE + ($urandom % NUM_GP));
            for (int b = 0; b < nb; b++) tx_buf[b] = 8'($urandom);
            write_txn(code, nb, a);
            tx_buf[0] = 8'($urandom % 2); write_txn(0, 1, 13'h004);
            if ($urandom % 3 == 0) begin
                tx_buf[0] = 8'h01; write_txn(0, 1, 13'h232);
            end
            chk_active("R8 random");
            read_check(code, nb, a, m_lsb ? "R4 random" : "R3 random");
        end

        // R7: soft reset
        tx_buf[0] = 8'hAB; tx_buf[1] = 8'hCD; write_txn(1, 2, 13'h006);
        tx_buf[0] = 8'h24; write_txn(0, 1, 13'h000);
        chk("R7 framing default", {30'b0, m_lsb, m_four}, 32'd0);
        chk_active("R7 active");
        read_check(0, 1, 13'h000, "R7 cfg");
        read_check(2, 3, 13'h006, "R7 regs");
        read_check(3, 5, 13'h01F, "R7 bank");

        finish_run();
    end

endmodule